// File: doc/BRIEF.md
# Dual-Lane DDR Serial Frame Transmitter

This block turns one framed message into a source-synchronous serial stream. The stream has a forwarded clock and one or two data lanes, and it is double data rate: a new beat goes onto the lanes at every edge of the forwarded clock, rising and falling. A frame carries a 4-bit type code, an 8-bit user byte, N 16-bit words and a 4-bit tag. The block wraps them in fixed delimiters and appends an 8-bit CRC. Between frames the clock and both lanes sit at logic 1.

The host first writes the words into an internal buffer by address. It then pulses `start` together with the type, user byte, tag, word count, lane mode and clock half-period. These values are captured on that cycle. `busy` stays high for the whole frame, and `done` pulses once when the line has returned to idle. With two lanes, only the payload (user byte, words and CRC) is split across the lanes. The delimiters, type and tag are copied onto both lanes. As a result the bits carried per clock period change within one frame.

Top module: `ddr_frame_tx`

## Requirements
- R1: After reset, and at every cycle where `busy` is low, `tx_clk`, `tx_lane0` and `tx_lane1` are all 1 and `done` is 0 except for its completion pulse.
- R2: In single-lane mode, `tx_lane0` carries the frame one bit per beat, MSB first of every field: 1111, then 1001, then the type, the user byte, words 0..N-1, the CRC, the tag, 0110 and 1111. `tx_lane1` stays at 1 for the whole frame. Code 0011 is the type used for 8-word frames.
- R3: In two-lane mode, the payload bits (user byte, words, CRC, counted from 0 at the first user bit) travel two per beat, with the even-indexed bit on `tx_lane0` and the odd-indexed bit on `tx_lane1`. Every other field travels one bit per beat, and that bit is driven on both lanes.
- R4: Each beat starts at a `tx_clk` edge, and each half-period of `tx_clk` lasts `cfg_half` system cycles, so the divisor is 2·`cfg_half`. The first edge is falling and comes on the clock edge that accepts `start`. The last edge is rising.
- R5: A frame lasts 32+8N beats (16+4N `tx_clk` periods) in two-lane mode and 40+16N beats in single-lane mode. An 8-word two-lane frame therefore takes 48 periods. `busy` is high for beats·`cfg_half` cycles.
- R6: The CRC is CRC-8 with polynomial 0x07 and initial value 0x00. It is computed MSB first over the user byte followed by the words, and it is sent MSB first.
- R7: A `start` while `busy` is high is ignored and is not queued. A buffer write while `busy` is high is ignored.
- R8: `done` is high for exactly one cycle, in the first cycle where `busy` is low after the final half-period.
- R9: With N = 0, the CRC follows the user byte directly, and the frame has no word field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_two_lane | input | 1 | 1 selects two lanes; captured at start |
| cfg_half | input | HALF_W | Half-period of tx_clk in system cycles (≥1); captured at start |
| load_en | input | 1 | Write one word into the buffer |
| load_addr | input | ADDR_W | Buffer word index |
| load_data | input | 16 | Word value |
| start | input | 1 | Begin a frame when idle |
| frame_type | input | 4 | Type code |
| user_data | input | 8 | User byte |
| frame_tag | input | 4 | Tag |
| word_count | input | CNT_W | Number of words N (0..MAX_WORDS) |
| tx_clk | output | 1 | Forwarded DDR clock |
| tx_lane0 | output | 1 | Data lane 0 |
| tx_lane1 | output | 1 | Data lane 1 |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `start` is driven only on clean cycle boundaries and that the host never relies on a start or a load issued during a frame. They also assume `cfg_half` is at least 1, `word_count` does not exceed the buffer depth, and the words are written before `start`. The stimulus loads every word while the block is idle and uses `cfg_half` from 1 to 3. It issues a stray start and a stray load mid-frame only to show that they have no effect. It sweeps both lane modes over N of 0, 1, 2, 8 and 16.

// File: rtl/ddr_frame_tx_pkg.sv
// Shared types and constants for the DDR frame transmitter.
// Assumes field lengths are even so two-lane payload steps never straddle a field.
package ddr_frame_tx_pkg;

    typedef enum logic [3:0] {
        FLD_IDLE, FLD_PRE, FLD_SOF, FLD_TYPE, FLD_USER, FLD_WORD,
        FLD_CRC, FLD_TAG, FLD_EOF, FLD_POST, FLD_END
    } field_e;

    localparam logic [3:0] PRE_CODE  = 4'b1111;
    localparam logic [3:0] SOF_CODE  = 4'b1001;
    localparam logic [3:0] EOF_CODE  = 4'b0110;
    localparam logic [3:0] POST_CODE = 4'b1111;
    localparam logic [7:0] CRC_POLY  = 8'h07;

    // True for fields that may be split across two lanes.
    function automatic logic is_payload(input field_e f);
        return (f == FLD_USER) || (f == FLD_WORD) || (f == FLD_CRC);
    endfunction

    // Bit length of one field (one word for FLD_WORD).
    function automatic logic [4:0] field_len(input field_e f);
        case (f)
            FLD_USER, FLD_CRC: return 5'd8;
            FLD_WORD:          return 5'd16;
            default:           return 5'd4;
        endcase
    endfunction

endpackage

// File: rtl/ddr_frame_tx_crc8.sv
// Combinational CRC-8 step over one or two MSB-first bits.
// Assumes bit_a precedes bit_b in the stream.
module ddr_frame_tx_crc8
    import ddr_frame_tx_pkg::*;
(
    input  logic [7:0] crc_in,
    input  logic       bit_a,
    input  logic       bit_b,
    input  logic       use_b,
    output logic [7:0] crc_out
);

    function automatic logic [7:0] step(input logic [7:0] c, input logic b);
        logic fb;
        fb = c[7] ^ b;
        return {c[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
    endfunction

    logic [7:0] after_a;

    // Fold in the first bit, then optionally the second.
    always_comb begin
        after_a = step(crc_in, bit_a);
        crc_out = use_b ? step(after_a, bit_b) : after_a;
    end

endmodule

// File: rtl/ddr_frame_tx_clkdiv.sv
// Beat tick generator: pulses tick once every `half` cycles while running.
// Assumes half >= 1 (0 is treated as 1); restart realigns the count.
module ddr_frame_tx_clkdiv #(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic [HALF_W-1:0] half,
    output logic              tick
);

    logic [HALF_W-1:0] cnt_q;
    logic [HALF_W-1:0] limit;

    // Terminal count for one half-period.
    always_comb begin
        limit = (half == '0) ? '0 : half - HALF_W'(1);
        tick  = run && (cnt_q == limit);
    end

    // Half-period counter.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run || tick) cnt_q <= '0;
        else                                   cnt_q <= cnt_q + HALF_W'(1);
    end

endmodule

// File: rtl/ddr_frame_tx_seq.sv
// Field sequencer: walks the frame fields, drives both lanes one beat at a
// time and accumulates the CRC over the payload as it is sent.
// Assumes tick arrives only while busy and nwords <= buffer depth.
module ddr_frame_tx_seq
    import ddr_frame_tx_pkg::*;
#(
    parameter int CNT_W  = 5,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              tick,
    input  logic              two_lane,
    input  logic [3:0]        ftype,
    input  logic [7:0]        user,
    input  logic [3:0]        tag,
    input  logic [CNT_W-1:0]  nwords,
    input  logic [15:0]       rd_word,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              beat,
    output logic              busy,
    output logic              done,
    output logic              lane0,
    output logic              lane1
);

    field_e            field_q, nxt_field;
    logic [4:0]        idx_q, nxt_idx, sum_idx, step;
    logic [ADDR_W-1:0] widx_q, nxt_widx;
    logic [7:0]        crc_q, crc_nx, user_q;
    logic [3:0]        type_q, tag_q;
    logic [CNT_W-1:0]  n_q;
    logic              two_q, pay, bit_a, bit_b, emit, finish;

    // Bit i (MSB first) of the current field.
    function automatic logic pick(input field_e f, input logic [4:0] i);
        case (f)
            FLD_PRE:  return PRE_CODE[2'd3 - i[1:0]];
            FLD_SOF:  return SOF_CODE[2'd3 - i[1:0]];
            FLD_TYPE: return type_q[2'd3 - i[1:0]];
            FLD_USER: return user_q[3'd7 - i[2:0]];
            FLD_WORD: return rd_word[4'd15 - i[3:0]];
            FLD_CRC:  return crc_q[3'd7 - i[2:0]];
            FLD_TAG:  return tag_q[2'd3 - i[1:0]];
            FLD_EOF:  return EOF_CODE[2'd3 - i[1:0]];
            FLD_POST: return POST_CODE[2'd3 - i[1:0]];
            default:  return 1'b1;
        endcase
    endfunction

    assign rd_addr = widx_q;

    ddr_frame_tx_crc8 u_crc (
        .crc_in (crc_q),
        .bit_a  (bit_a),
        .bit_b  (bit_b),
        .use_b  (two_q),
        .crc_out(crc_nx)
    );

    // Current beat bits, step size and the position after this beat.
    always_comb begin
        pay      = is_payload(field_q);
        step     = (two_q && pay) ? 5'd2 : 5'd1;
        bit_a    = pick(field_q, idx_q);
        bit_b    = pick(field_q, idx_q + 5'd1);
        emit     = tick && busy && (field_q != FLD_END);
        finish   = tick && busy && (field_q == FLD_END);
        beat     = accept || emit;
        sum_idx  = idx_q + step;
        nxt_field = field_q;
        nxt_idx   = sum_idx;
        nxt_widx  = widx_q;
        if (sum_idx == field_len(field_q)) begin
            nxt_idx = '0;
            case (field_q)
                FLD_PRE:  nxt_field = FLD_SOF;
                FLD_SOF:  nxt_field = FLD_TYPE;
                FLD_TYPE: nxt_field = FLD_USER;
                FLD_USER: nxt_field = (n_q == '0) ? FLD_CRC : FLD_WORD;
                FLD_WORD: begin
                    if (CNT_W'(widx_q) + CNT_W'(1) == n_q) nxt_field = FLD_CRC;
                    else nxt_widx = widx_q + ADDR_W'(1);
                end
                FLD_CRC:  nxt_field = FLD_TAG;
                FLD_TAG:  nxt_field = FLD_EOF;
                FLD_EOF:  nxt_field = FLD_POST;
                FLD_POST: nxt_field = FLD_END;
                default:  nxt_field = FLD_END;
            endcase
        end
    end

    // Frame state, captured parameters and lane outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_q <= FLD_IDLE;
            idx_q   <= '0;
            widx_q  <= '0;
            crc_q   <= '0;
            two_q   <= 1'b0;
            type_q  <= '0;
            user_q  <= '0;
            tag_q   <= '0;
            n_q     <= '0;
            lane0   <= 1'b1;
            lane1   <= 1'b1;
            busy    <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= finish;
            if (accept) begin
                // Beat 0 is the first preamble bit (a 1 on both lanes).
                two_q   <= two_lane;
                type_q  <= ftype;
                user_q  <= user;
                tag_q   <= tag;
                n_q     <= nwords;
                field_q <= FLD_PRE;
                idx_q   <= 5'd1;
                widx_q  <= '0;
                crc_q   <= '0;
                lane0   <= 1'b1;
                lane1   <= 1'b1;
                busy    <= 1'b1;
            end else if (emit) begin
                lane0 <= bit_a;
                lane1 <= !two_q ? 1'b1 : (pay ? bit_b : bit_a);
                if (field_q == FLD_USER || field_q == FLD_WORD) crc_q <= crc_nx;
                field_q <= nxt_field;
                idx_q   <= nxt_idx;
                widx_q  <= nxt_widx;
            end else if (finish) begin
                busy    <= 1'b0;
                field_q <= FLD_IDLE;
                lane0   <= 1'b1;
                lane1   <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ddr_frame_tx.sv
// Top of the DDR frame transmitter: word buffer, start capture, forwarded
// clock register and the beat/sequencer pair.
// Assumes words are loaded while idle and word_count <= MAX_WORDS.
module ddr_frame_tx #(
    parameter  int MAX_WORDS = 16,
    parameter  int HALF_W    = 8,
    localparam int CNT_W     = $clog2(MAX_WORDS + 1),
    localparam int ADDR_W    = $clog2(MAX_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_two_lane,
    input  logic [HALF_W-1:0] cfg_half,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [15:0]       load_data,
    input  logic              start,
    input  logic [3:0]        frame_type,
    input  logic [7:0]        user_data,
    input  logic [3:0]        frame_tag,
    input  logic [CNT_W-1:0]  word_count,
    output logic              tx_clk,
    output logic              tx_lane0,
    output logic              tx_lane1,
    output logic              busy,
    output logic              done
);

    logic [15:0]       buf_q [MAX_WORDS];
    logic [ADDR_W-1:0] rd_addr;
    logic [HALF_W-1:0] half_q;
    logic              accept, tick, beat;

    assign accept = start && !busy;

    // Word buffer; writes are dropped while a frame is running.
    always_ff @(posedge clk) begin
        if (load_en && !busy) buf_q[load_addr] <= load_data;
    end

    // Half-period capture and forwarded clock (toggles once per beat).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= HALF_W'(1);
            tx_clk <= 1'b1;
        end else begin
            if (accept) half_q <= cfg_half;
            if (beat)   tx_clk <= !tx_clk;
        end
    end

    ddr_frame_tx_clkdiv #(.HALF_W(HALF_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (busy),
        .restart(accept),
        .half   (half_q),
        .tick   (tick)
    );

    ddr_frame_tx_seq #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .tick    (tick),
        .two_lane(cfg_two_lane),
        .ftype   (frame_type),
        .user    (user_data),
        .tag     (frame_tag),
        .nwords  (word_count),
        .rd_word (buf_q[rd_addr]),
        .rd_addr (rd_addr),
        .beat    (beat),
        .busy    (busy),
        .done    (done),
        .lane0   (tx_lane0),
        .lane1   (tx_lane1)
    );

endmodule

// File: rtl/ddr_frame_tx_chk.sv
// Port-level protocol checks for ddr_frame_tx, bound into every instance.
// Assumes reset is asserted from time zero.
module ddr_frame_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic tx_clk,
    input logic tx_lane0,
    input logic tx_lane1,
    input logic busy,
    input logic done
);

    // R1
    idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (tx_clk && tx_lane0 && tx_lane1));

    // R4
    launch_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !tx_clk));

    // R4
    clk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tx_clk) |-> busy);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R7
    busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

endmodule

bind ddr_frame_tx ddr_frame_tx_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .tx_clk  (tx_clk),
    .tx_lane0(tx_lane0),
    .tx_lane1(tx_lane1),
    .busy    (busy),
    .done    (done)
);

// File: tb/ddr_frame_tx_tb.sv
`timescale 1ns/1ps
// Sweeps lane mode, word count and half-period; rebuilds each expected
// beat stream arithmetically and compares it with the captured lanes.
module ddr_frame_tx_tb;

    localparam int MW = 16;
    localparam int HW = 8;
    localparam int CW = $clog2(MW + 1);
    localparam int AW = $clog2(MW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_two_lane = 1'b0;
    logic [HW-1:0] cfg_half = 8'd1;
    logic          load_en = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic [15:0]   load_data = '0;
    logic          start = 1'b0;
    logic [3:0]    frame_type = '0;
    logic [7:0]    user_data = '0;
    logic [3:0]    frame_tag = '0;
    logic [CW-1:0] word_count = '0;
    logic          tx_clk, tx_lane0, tx_lane1, busy, done;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    ddr_frame_tx #(.MAX_WORDS(MW), .HALF_W(HW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_two_lane(cfg_two_lane), .cfg_half(cfg_half),
        .load_en(load_en), .load_addr(load_addr), .load_data(load_data),
        .start(start), .frame_type(frame_type), .user_data(user_data),
        .frame_tag(frame_tag), .word_count(word_count),
        .tx_clk(tx_clk), .tx_lane0(tx_lane0), .tx_lane1(tx_lane1),
        .busy(busy), .done(done)
    );

    always #2.5 clk = ~clk;

    // Capture state
    int cyc = 0;
    bit cap_en = 0;
    int cap_n, busy_cnt, done_cnt, done_busy;
    bit cap0 [0:1023];
    bit cap1 [0:1023];
    bit capc [0:1023];
    int capt [0:1023];
    logic prev_clk = 1'b1;

    // Expected state
    bit e_b [0:1023];
    int e_k [0:1023];
    int e_n;
    bit eb0 [0:1023];
    bit eb1 [0:1023];
    int ebk [0:1023];
    int eb_n;

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (cap_en) begin
            if (tx_clk !== prev_clk && cap_n < 1024) begin
                cap0[cap_n] = tx_lane0;
                cap1[cap_n] = tx_lane1;
                capc[cap_n] = tx_clk;
                capt[cap_n] = cyc;
                cap_n++;
            end
            if (busy) busy_cnt++;
            if (done) begin
                done_cnt++;
                if (busy) done_busy++;
            end
        end
        prev_clk = tx_clk;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mkword(input int n, input int i);
        return 16'((32'hB4C1 ^ (i * 32'h01F3) ^ (n << 11)) & 32'hFFFF);
    endfunction

    function automatic logic [7:0] crc_upd(input logic [7:0] c, input logic [15:0] v, input int w);
        logic [7:0] r = c;
        for (int j = w - 1; j >= 0; j--) begin
            logic fb = r[7] ^ v[j];
            r = {r[6:0], 1'b0};
            if (fb) r = r ^ 8'h07;
        end
        return r;
    endfunction

    task automatic add_bits(input logic [15:0] v, input int w, input int kind);
        for (int j = w - 1; j >= 0; j--) begin
            e_b[e_n] = v[j];
            e_k[e_n] = kind;
            e_n++;
        end
    endtask

    task automatic build_expect(input bit two, input int n, input logic [3:0] ft,
                                input logic [7:0] uq, input logic [3:0] tg);
        logic [7:0] c = crc_upd(8'h00, {8'h00, uq}, 8);
        e_n = 0;
        add_bits(16'hF, 4, 0);
        add_bits(16'h9, 4, 0);
        add_bits({12'h0, ft}, 4, 0);
        add_bits({8'h0, uq}, 8, 1);
        for (int i = 0; i < n; i++) begin
            add_bits(mkword(n, i), 16, 1);
            c = crc_upd(c, mkword(n, i), 16);
        end
        add_bits({8'h0, c}, 8, 2);
        add_bits({12'h0, tg}, 4, 0);
        add_bits(16'h6, 4, 0);
        add_bits(16'hF, 4, 0);
        eb_n = 0;
        for (int i = 0; i < e_n; ) begin
            if (two && e_k[i] != 0) begin
                eb0[eb_n] = e_b[i];
                eb1[eb_n] = e_b[i + 1];
                ebk[eb_n] = e_k[i];
                i += 2;
            end else begin
                eb0[eb_n] = e_b[i];
                eb1[eb_n] = two ? e_b[i] : 1'b1;
                ebk[eb_n] = e_k[i];
                i += 1;
            end
            eb_n++;
        end
    endtask

    task automatic run_frame(input bit two, input int n, input int h,
                             input bit reload, input bit disturb);
        logic [3:0] ft = (n == 8) ? 4'b0011 : 4'(n);
        logic [7:0] uq = 8'((n * 37 + h * 11 + (two ? 90 : 0)) & 255);
        logic [3:0] tg = 4'((n + h + 5) & 15);
        int beats = two ? (32 + 8 * n) : (40 + 16 * n);
        int g = 0;
        int m_main = 0;
        int m_crc = 0;
        int iv_bad = 0;
        int lim;
        if (reload) begin
            for (int i = 0; i < n; i++) begin
                @(negedge clk);
                load_en = 1'b1;
                load_addr = AW'(i);
                load_data = mkword(n, i);
            end
            @(negedge clk);
            load_en = 1'b0;
        end
        build_expect(two, n, ft, uq, tg);
        @(negedge clk);
        cfg_two_lane = two;
        cfg_half = HW'(h);
        frame_type = ft;
        user_data = uq;
        frame_tag = tg;
        word_count = CW'(n);
        cap_n = 0; busy_cnt = 0; done_cnt = 0; done_busy = 0;
        cap_en = 1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (done_cnt == 0 && g < 20000) begin
            @(negedge clk);
            g++;
            if (disturb && g == 3) begin
                // R7: stray start and stray load mid-frame
                start = 1'b1;
                word_count = CW'((n == 0) ? 3 : 0);
                frame_type = ~ft;
                cfg_half = HW'(h + 1);
                load_en = 1'b1;
                load_addr = '0;
                load_data = ~mkword(n, 0);
            end else begin
                start = 1'b0;
                load_en = 1'b0;
            end
        end
        start = 1'b0;
        load_en = 1'b0;
        repeat (4) @(negedge clk);
        cap_en = 0;
        chk(cap_n == beats, (n == 0) ? "R9 beat count" : "R5 beat count", cap_n, beats);
        chk(busy_cnt == beats * h, "R5 busy length", busy_cnt, beats * h);
        lim = (cap_n < eb_n) ? cap_n : eb_n;
        for (int k = 0; k < lim; k++) begin
            if (cap0[k] !== eb0[k] || cap1[k] !== eb1[k]) begin
                if (ebk[k] == 2) m_crc++;
                else m_main++;
            end
        end
        chk(m_main == 0, two ? "R3 lane content" : "R2 lane content", m_main, 0);
        chk(m_crc == 0, "R6 crc beats", m_crc, 0);
        for (int k = 1; k < cap_n; k++)
            if (capt[k] - capt[k - 1] != h) iv_bad++;
        chk(iv_bad == 0, "R4 half-period", iv_bad, 0);
        chk(cap_n > 0 && capc[0] == 1'b0, "R4 first edge falling", cap_n > 0 ? int'(capc[0]) : -1, 0);
        chk(cap_n > 0 && capc[cap_n - 1] == 1'b1, "R4 last edge rising",
            cap_n > 0 ? int'(capc[cap_n - 1]) : -1, 1);
        chk(done_cnt == 1 && done_busy == 0, "R8 done pulse", done_cnt, 1);
        chk(busy === 1'b0, disturb ? "R7 no queued start" : "R1 idle after frame", int'(busy), 0);
        chk({tx_clk, tx_lane0, tx_lane1} === 3'b111, "R1 idle line",
            int'({tx_clk, tx_lane0, tx_lane1}), 7);
    endtask

    initial begin
        int nlist [5] = '{0, 1, 2, 8, 16};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R1 reset flags", int'({busy, done}), 0);
        chk({tx_clk, tx_lane0, tx_lane1} === 3'b111, "R1 reset line",
            int'({tx_clk, tx_lane0, tx_lane1}), 7);
        for (int two = 0; two < 2; two++)
            for (int ni = 0; ni < 5; ni++)
                for (int h = 1; h <= 3; h++)
                    run_frame(two[0], nlist[ni], h, 1'b1, 1'b0);
        // R7: stray start/load during a frame, then reuse the buffer unchanged
        run_frame(1'b1, 8, 2, 1'b1, 1'b1);
        run_frame(1'b1, 8, 2, 1'b0, 1'b0);
        run_frame(1'b0, 3, 1, 1'b1, 1'b1);
        run_frame(1'b0, 3, 1, 1'b0, 1'b0);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule